// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block sits at the front of a small single-instruction multiple-thread core. Each cycle it picks one resident warp to issue. A warp is a group of 32 threads that share one program counter. The block presents the chosen warp's number, its program counter and the 32-lane mask of threads that are enabled. Fetch, decode, execution lanes and memory sit outside the block. They report back to it through simple event inputs: warp launch, branch resolution with a per-lane taken vector, cache miss, miss return, and warp exit.

The block holds a table of eight warps. Each entry has a valid bit, a ready bit, a program counter, an active lane mask, and a four-deep reconvergence stack. Warps are picked round robin. A warp that is waiting on memory is skipped, so the core keeps issuing from the other warps. When a branch splits a warp's lanes, the taken lanes run first and the other lanes run afterwards. Full width is restored once both groups have reached the reconvergence address.

Top module: `warp_sched`

## Requirements
- R1: While reset is held and just after it is released, no warp is resident, `issueValid` is 0 and `stackErr` is 0.
- R2: While `issueValid` is 1, `issueWarp`, `issuePc` and `issueMask` describe the warp being issued this cycle. A launched warp first issues at its launch PC with its launch mask. The issued warp's PC is one higher in the next cycle unless a branch, a launch or a reconvergence step for that warp happens in the same cycle.
- R3: The search for the next warp starts at one past the warp that issued last (warp 7 wraps to warp 0). It takes the first warp found that is valid, ready, not blocked and not at a reconvergence step.
- R4: A miss event for a warp clears its ready bit, and the warp is skipped until it becomes ready again.
- R5: A miss-return event for a warp sets its ready bit, and the warp becomes eligible again.
- R6: When no warp is eligible, `issueValid` is 0 in that cycle.
- R7: An exit event clears the warp's valid bit, and the warp never issues again until it is relaunched. A later miss return does not bring it back. Exit takes priority over a launch of the same warp in the same cycle.
- R8: A divergent branch is one where the taken vector ANDed with the active mask is neither zero nor the whole mask. It pushes the reconvergence PC, the fall-through PC, the not-taken lanes and the current mask onto the stack. The warp then continues at the branch target with only the taken lanes. A branch takes priority over the issue increment in the same cycle.
- R9: The first time the warp's PC equals the reconvergence PC on top of the stack, the warp does not issue that cycle. In the next cycle it continues at the fall-through PC with the not-taken lanes.
- R10: The second time the PC equals that reconvergence PC, the warp again does not issue for one cycle. The entry is then popped, and the warp continues at the same PC with the mask it had before the branch.
- R11: A branch that is uniform across the active lanes changes only the PC (to the target if all lanes are taken, to the fall-through if none are) and pushes nothing.
- R12: A divergent branch that finds the four-entry stack full sets `stackErr`, which stays 1 until reset. The offending warp stops issuing, and the other warps keep issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch a warp this cycle |
| launchWarp | input | 3 | Warp number to launch |
| launchPc | input | 16 | Start PC of the launched warp |
| launchMask | input | 32 | Initial lane mask (nonzero) |
| brValid | input | 1 | A branch of a warp resolved this cycle |
| brWarp | input | 3 | Warp that executed the branch |
| brTaken | input | 32 | Per-lane taken outcome |
| brTarget | input | 16 | Taken-path PC |
| brFall | input | 16 | Not-taken-path PC |
| brReconv | input | 16 | Reconvergence PC of the branch |
| missValid | input | 1 | A warp missed in the cache |
| missWarp | input | 3 | Warp that missed |
| retValid | input | 1 | Miss data returned |
| retWarp | input | 3 | Warp whose miss returned |
| exitValid | input | 1 | A warp finished |
| exitWarp | input | 3 | Warp that finished |
| issueValid | output | 1 | A warp is issued this cycle |
| issueWarp | output | 3 | Issued warp number |
| issuePc | output | 16 | PC of the issued warp |
| issueMask | output | 32 | Active lanes of the issued warp |
| stackErr | output | 1 | Sticky reconvergence-stack overflow flag |

## Verification
The assertions rely on the neighbouring blocks behaving sensibly. Launch masks are never zero. Launch, exit and branch events never name the same warp in the same cycle, except where the stated priority settles it. A branch is only reported for a warp that is resident. The stimulus respects all of this by construction: each cycle carries at most one event per warp, and it only launches warps with a full mask. Miss, return and exit events are placed so that the expected warp order can be computed by hand from the round-robin rule alone.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int NUM_WARPS = 8;
  localparam int LANES     = 32;
  localparam int PC_W      = 16;
  localparam int STACK_D   = 4;
  localparam int WID_W     = $clog2(NUM_WARPS);
  localparam int SP_W      = $clog2(STACK_D + 1);
  localparam int IDX_W     = $clog2(STACK_D);

  typedef struct packed {
    logic             issueEn;
    logic [WID_W-1:0] issueWarp;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [PC_W-1:0]  reconvPc;
    logic [PC_W-1:0]  pendPc;
    logic [LANES-1:0] pendMask;
    logic [LANES-1:0] mergeMask;
    logic             pendDone;
  } stackEnt_t;
endpackage

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] eligible,
  output ctrlStrobe_t          strobe
);
  logic [WID_W-1:0] rrPtr;
  logic [WID_W-1:0] pick;
  logic             found;

  // first eligible warp at or after the rotating pointer
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      int j;
      j = (int'(rrPtr) + k) % NUM_WARPS;
      if (!found && eligible[j]) begin
        found = 1'b1;
        pick  = WID_W'(j);
      end
    end
  end

  assign strobe.issueEn   = found;
  assign strobe.issueWarp = pick;

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (found) rrPtr <= WID_W'((int'(pick) + 1) % NUM_WARPS);
  end
endmodule

// File: rtl/warp_sched_dp.sv
module warp_sched_dp
  import warp_sched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic                 launchValid,
  input  logic [WID_W-1:0]     launchWarp,
  input  logic [PC_W-1:0]      launchPc,
  input  logic [LANES-1:0]     launchMask,
  input  logic                 brValid,
  input  logic [WID_W-1:0]     brWarp,
  input  logic [LANES-1:0]     brTaken,
  input  logic [PC_W-1:0]      brTarget,
  input  logic [PC_W-1:0]      brFall,
  input  logic [PC_W-1:0]      brReconv,
  input  logic                 missValid,
  input  logic [WID_W-1:0]     missWarp,
  input  logic                 retValid,
  input  logic [WID_W-1:0]     retWarp,
  input  logic                 exitValid,
  input  logic [WID_W-1:0]     exitWarp,
  output logic [NUM_WARPS-1:0] eligible,
  output logic [PC_W-1:0]      issuePc,
  output logic [LANES-1:0]     issueMask,
  output logic                 stackErr
);
  logic [NUM_WARPS-1:0] vld, rdy, blk, hit;
  logic [PC_W-1:0]      pc   [NUM_WARPS];
  logic [LANES-1:0]     mask [NUM_WARPS];
  logic [SP_W-1:0]      sp   [NUM_WARPS];
  stackEnt_t            stk  [NUM_WARPS][STACK_D];
  stackEnt_t            top  [NUM_WARPS];
  logic [IDX_W-1:0]     topIdx [NUM_WARPS];

  logic [LANES-1:0] brAct, brTk, brNt;
  logic             brDiverge;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [SP_W-1:0] spM1;
    assign spM1      = sp[w] - SP_W'(1);
    assign topIdx[w] = spM1[IDX_W-1:0];
    assign top[w]    = stk[w][topIdx[w]];
    assign hit[w]    = vld[w] && (sp[w] != '0) && (pc[w] == top[w].reconvPc);
    assign eligible[w] = vld[w] && rdy[w] && !blk[w] && !hit[w];
  end

  assign brAct     = mask[brWarp];
  assign brTk      = brAct & brTaken;
  assign brNt      = brAct & ~brTaken;
  assign brDiverge = (brTk != '0) && (brNt != '0);

  assign issuePc   = strobe.issueEn ? pc[strobe.issueWarp]   : '0;
  assign issueMask = strobe.issueEn ? mask[strobe.issueWarp] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      rdy <= '0;
      blk <= '0;
      stackErr <= 1'b0;
      for (int w = 0; w < NUM_WARPS; w++) begin
        pc[w]   <= '0;
        mask[w] <= '0;
        sp[w]   <= '0;
        for (int d = 0; d < STACK_D; d++) stk[w][d] <= '0;
      end
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        if (exitValid && exitWarp == WID_W'(w)) begin
          vld[w] <= 1'b0;
        end else if (launchValid && launchWarp == WID_W'(w)) begin
          vld[w]  <= 1'b1;
          rdy[w]  <= 1'b1;
          blk[w]  <= 1'b0;
          pc[w]   <= launchPc;
          mask[w] <= launchMask;
          sp[w]   <= '0;
        end else if (vld[w]) begin
          if (brValid && brWarp == WID_W'(w)) begin
            if (!brDiverge) begin
              pc[w] <= (brTk != '0) ? brTarget : brFall;
            end else if (sp[w] == SP_W'(STACK_D)) begin
              blk[w]   <= 1'b1;
              stackErr <= 1'b1;
            end else begin
              stk[w][sp[w][IDX_W-1:0]] <= '{reconvPc: brReconv, pendPc: brFall,
                                            pendMask: brNt, mergeMask: brAct,
                                            pendDone: 1'b0};
              sp[w]   <= sp[w] + SP_W'(1);
              pc[w]   <= brTarget;
              mask[w] <= brTk;
            end
          end else if (hit[w]) begin
            if (!top[w].pendDone) begin
              pc[w]   <= top[w].pendPc;
              mask[w] <= top[w].pendMask;
              stk[w][topIdx[w]].pendDone <= 1'b1;
            end else begin
              mask[w] <= top[w].mergeMask;
              sp[w]   <= sp[w] - SP_W'(1);
            end
          end else if (strobe.issueEn && strobe.issueWarp == WID_W'(w)) begin
            pc[w] <= pc[w] + PC_W'(1);
          end
          if (missValid && missWarp == WID_W'(w)) rdy[w] <= 1'b0;
          else if (retValid && retWarp == WID_W'(w)) rdy[w] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             launchValid,
  input  logic [WID_W-1:0] launchWarp,
  input  logic [PC_W-1:0]  launchPc,
  input  logic [LANES-1:0] launchMask,
  input  logic             brValid,
  input  logic [WID_W-1:0] brWarp,
  input  logic [LANES-1:0] brTaken,
  input  logic [PC_W-1:0]  brTarget,
  input  logic [PC_W-1:0]  brFall,
  input  logic [PC_W-1:0]  brReconv,
  input  logic             missValid,
  input  logic [WID_W-1:0] missWarp,
  input  logic             retValid,
  input  logic [WID_W-1:0] retWarp,
  input  logic             exitValid,
  input  logic [WID_W-1:0] exitWarp,
  output logic             issueValid,
  output logic [WID_W-1:0] issueWarp,
  output logic [PC_W-1:0]  issuePc,
  output logic [LANES-1:0] issueMask,
  output logic             stackErr
);
  ctrlStrobe_t          strobe;
  logic [NUM_WARPS-1:0] eligible;

  warp_sched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .strobe(strobe)
  );

  warp_sched_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .launchValid(launchValid), .launchWarp(launchWarp),
    .launchPc(launchPc), .launchMask(launchMask),
    .brValid(brValid), .brWarp(brWarp), .brTaken(brTaken),
    .brTarget(brTarget), .brFall(brFall), .brReconv(brReconv),
    .missValid(missValid), .missWarp(missWarp),
    .retValid(retValid), .retWarp(retWarp),
    .exitValid(exitValid), .exitWarp(exitWarp),
    .eligible(eligible), .issuePc(issuePc), .issueMask(issueMask),
    .stackErr(stackErr)
  );

  assign issueValid = strobe.issueEn;
  assign issueWarp  = strobe.issueWarp;
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk
  import warp_sched_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             launchValid,
  input logic [WID_W-1:0] launchWarp,
  input logic             brValid,
  input logic [WID_W-1:0] brWarp,
  input logic [LANES-1:0] brTaken,
  input logic [PC_W-1:0]  brTarget,
  input logic             exitValid,
  input logic [WID_W-1:0] exitWarp,
  input logic             issueValid,
  input logic [WID_W-1:0] issueWarp,
  input logic [PC_W-1:0]  issuePc,
  input logic [LANES-1:0] issueMask,
  input logic             stackErr
);
  logic brOnIssued, brSplit, brAll;
  assign brOnIssued = issueValid && brValid && brWarp == issueWarp &&
                      !(launchValid && launchWarp == issueWarp) &&
                      !(exitValid && exitWarp == issueWarp);
  assign brSplit = brOnIssued && ((brTaken & issueMask) != '0) &&
                   ((brTaken & issueMask) != issueMask);
  assign brAll   = brOnIssued && ((brTaken & issueMask) == issueMask);

  // R12: overflow flag never falls
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(stackErr) |-> stackErr);

  // R2: an issued warp always carries at least one lane
  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> issueMask != '0);

  // R8: after a split, the same warp issues only the taken lanes
  a_r8_taken_lanes: assert property (@(posedge clk) disable iff (!rstN)
    brSplit |=> (issueValid && issueWarp == $past(issueWarp)) ->
                (issueMask == $past(brTaken & issueMask)));

  // R11: an all-taken branch keeps the mask and jumps to the target
  a_r11_uniform: assert property (@(posedge clk) disable iff (!rstN)
    brAll |=> (issueValid && issueWarp == $past(issueWarp)) ->
              (issueMask == $past(issueMask) && issuePc == $past(brTarget)));

  // R7: a warp that just exited is not issued
  a_r7_exit_gone: assert property (@(posedge clk) disable iff (!rstN)
    exitValid |=> !(issueValid && issueWarp == $past(exitWarp)));
endmodule

bind warp_sched warp_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .launchValid(launchValid), .launchWarp(launchWarp),
  .brValid(brValid), .brWarp(brWarp), .brTaken(brTaken), .brTarget(brTarget),
  .exitValid(exitValid), .exitWarp(exitWarp), .issueValid(issueValid),
  .issueWarp(issueWarp), .issuePc(issuePc), .issueMask(issueMask),
  .stackErr(stackErr)
);

// File: tb/warp_sched_tb.sv
module warp_sched_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        launchValid = 1'b0;
  logic [2:0]  launchWarp = '0;
  logic [15:0] launchPc = '0;
  logic [31:0] launchMask = '0;
  logic        brValid = 1'b0;
  logic [2:0]  brWarp = '0;
  logic [31:0] brTaken = '0;
  logic [15:0] brTarget = '0, brFall = '0, brReconv = '0;
  logic        missValid = 1'b0;
  logic [2:0]  missWarp = '0;
  logic        retValid = 1'b0;
  logic [2:0]  retWarp = '0;
  logic        exitValid = 1'b0;
  logic [2:0]  exitWarp = '0;
  logic        issueValid;
  logic [2:0]  issueWarp;
  logic [15:0] issuePc;
  logic [31:0] issueMask;
  logic        stackErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  warp_sched u_dut (.*);

  task automatic nxt();
    @(negedge clk);
    launchValid = 1'b0; brValid = 1'b0; missValid = 1'b0;
    retValid = 1'b0; exitValid = 1'b0;
  endtask

  task automatic chkBit(string tag, logic act, logic expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, expv);
    end
  endtask

  task automatic expIssue(string tag, logic v, int w, int p, logic [31:0] m);
    nChecks++;
    if (issueValid !== v ||
        (v && (issueWarp !== 3'(w) || issuePc !== 16'(p) || issueMask !== m))) begin
      nFail++;
      $display("FAIL %s: got v=%0b w=%0d pc=%h m=%h expected v=%0b w=%0d pc=%h m=%h",
               tag, issueValid, issueWarp, issuePc, issueMask, v, w, 16'(p), m);
    end
  endtask

  task automatic launch(int w, int p);
    launchValid = 1'b1; launchWarp = 3'(w); launchPc = 16'(p); launchMask = FULL;
  endtask

  task automatic branch(int w, logic [31:0] tk, int tgt, int fall, int rc);
    brValid = 1'b1; brWarp = 3'(w); brTaken = tk;
    brTarget = 16'(tgt); brFall = 16'(fall); brReconv = 16'(rc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expIssue("R1 reset idle", 1'b0, 0, 0, FULL);
    chkBit("R1 reset err", stackErr, 1'b0);
    rstN = 1'b1;
    nxt(); expIssue("R1 after release", 1'b0, 0, 0, FULL); launch(0, 'h10);
    nxt(); expIssue("R2 first issue", 1'b1, 0, 'h10, FULL); launch(2, 'h20);
    nxt(); expIssue("R3 rotate to 2", 1'b1, 2, 'h20, FULL); launch(5, 'h50);
    nxt(); expIssue("R3 rotate to 5", 1'b1, 5, 'h50, FULL);
    nxt(); expIssue("R3 wrap to 0 R2 pc+1", 1'b1, 0, 'h11, FULL);
    nxt(); expIssue("R3 seq 2", 1'b1, 2, 'h21, FULL);
    nxt(); expIssue("R3 seq 5", 1'b1, 5, 'h51, FULL);
    nxt(); expIssue("R3 seq 0", 1'b1, 0, 'h12, FULL); missValid = 1'b1; missWarp = 3'd2;
    nxt(); expIssue("R4 skip missed 2", 1'b1, 5, 'h52, FULL);
    nxt(); expIssue("R4 back to 0", 1'b1, 0, 'h13, FULL); retValid = 1'b1; retWarp = 3'd2;
    nxt(); expIssue("R5 warp 2 returns", 1'b1, 2, 'h22, FULL); exitValid = 1'b1; exitWarp = 3'd0;
    nxt(); expIssue("R7 exited 0 skipped", 1'b1, 5, 'h53, FULL); exitValid = 1'b1; exitWarp = 3'd5;
    nxt(); expIssue("R7 only 2 left", 1'b1, 2, 'h23, FULL); missValid = 1'b1; missWarp = 3'd2;
    nxt(); expIssue("R6 none ready", 1'b0, 0, 0, FULL); exitValid = 1'b1; exitWarp = 3'd2;
    nxt(); expIssue("R6 none valid", 1'b0, 0, 0, FULL); retValid = 1'b1; retWarp = 3'd2;
    nxt(); expIssue("R7 return after exit", 1'b0, 0, 0, FULL); launch(3, 'h100);
    nxt(); expIssue("R2 launch 3", 1'b1, 3, 'h100, FULL);
    branch(3, 32'h0000_FFFF, 'h2FE, 'h2FF, 'h300);
    nxt(); expIssue("R8 taken lanes", 1'b1, 3, 'h2FE, 32'h0000_FFFF);
    nxt(); expIssue("R8 taken lanes step", 1'b1, 3, 'h2FF, 32'h0000_FFFF);
    nxt(); expIssue("R9 switch bubble", 1'b0, 0, 0, FULL);
    nxt(); expIssue("R9 not-taken lanes", 1'b1, 3, 'h2FF, 32'hFFFF_0000);
    nxt(); expIssue("R10 merge bubble", 1'b0, 0, 0, FULL);
    nxt(); expIssue("R10 merged mask", 1'b1, 3, 'h300, FULL);
    branch(3, FULL, 'h400, 'h301, 'h401);
    nxt(); expIssue("R11 all taken", 1'b1, 3, 'h400, FULL);
    nxt(); expIssue("R11 no push", 1'b1, 3, 'h401, FULL);
    branch(3, 32'h0, 'h600, 'h700, 'h701);
    nxt(); expIssue("R11 none taken", 1'b1, 3, 'h700, FULL);
    nxt(); expIssue("R11 none taken no push", 1'b1, 3, 'h701, FULL);
    branch(3, 32'hFFFF_0000, 'h800, 'h801, 'h7FF);
    nxt(); expIssue("R8 depth 1", 1'b1, 3, 'h800, 32'hFFFF_0000);
    branch(3, 32'hFF00_0000, 'h800, 'h801, 'h7FF);
    nxt(); expIssue("R8 depth 2", 1'b1, 3, 'h800, 32'hFF00_0000);
    branch(3, 32'hF000_0000, 'h800, 'h801, 'h7FF);
    nxt(); expIssue("R8 depth 3", 1'b1, 3, 'h800, 32'hF000_0000);
    branch(3, 32'hC000_0000, 'h800, 'h801, 'h7FF);
    nxt(); expIssue("R12 depth 4", 1'b1, 3, 'h800, 32'hC000_0000);
    chkBit("R12 no err at full", stackErr, 1'b0);
    branch(3, 32'h8000_0000, 'h800, 'h801, 'h7FF);
    nxt(); expIssue("R12 warp blocked", 1'b0, 0, 0, FULL);
    chkBit("R12 err raised", stackErr, 1'b1); launch(6, 'h900);
    nxt(); expIssue("R12 others issue", 1'b1, 6, 'h900, FULL);
    exitValid = 1'b1; exitWarp = 3'd3;
    nxt(); expIssue("R12 other continues", 1'b1, 6, 'h901, FULL);
    chkBit("R12 err sticky", stackErr, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule